// File: doc/BRIEF.md
# Receive FIFO flow-control monitor

This block watches how much data sits in a receive FIFO between a MAC and a DMA engine. It keeps two occupancy counts: one in bytes and one in complete frames. It raises a single level request, `fc_hold`, that tells the MAC to stop writing whenever either count goes above its programmed limit.

Each cycle the MAC side reports how many bytes it wrote and whether a frame ended. Each cycle the DMA side reports how many bytes it read and whether a whole frame has left the FIFO. Two configuration fields set the limits. The byte limit is set in steps of 256 bytes and runs from 256 to 65536 bytes. The frame limit runs from 1 to 24 frames. The FIFO storage itself lives elsewhere, and so do pause-frame generation and the DMA engine.

Top module: `rxq_hold_monitor`

## Requirements
- R1: A synchronous active-high `rst` clears both occupancy counts and drives `fc_hold` to 0. Traffic presented while `rst` is high leaves no trace in the counts.
- R2: Each cycle, the byte count gains `mac_wr_bytes` and loses `dma_rd_bytes`. A write and a read in the same cycle are netted into a single update.
- R3: When a read asks for more bytes than the count plus the same-cycle write holds, the byte count becomes 0 and does not wrap.
- R4: The byte limit is (`cfg_byte_steps` + 1) × 256. The byte condition is true when the byte count is strictly greater than this limit.
- R5: The frame count goes up by one on `mac_wr_eof` and down by one on `dma_frame_done`. Both in the same cycle leave it unchanged. A drain signalled at a count of 0 leaves it at 0.
- R6: The frame limit is `cfg_frame_limit`, with a value of 0 read as 1 and any value above 24 read as 24. The frame condition is true when the frame count is strictly greater than this limit.
- R7: `fc_hold` is the OR of the byte condition and the frame condition. Either one alone raises it.
- R8: `fc_hold` is a register. A beat sampled at clock edge k changes the counts at edge k, and the request reflects those counts at edge k+1. The request drops at the first edge after both counts are at or below their limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_wr_bytes | input | BEAT_W (4) | Bytes written into the FIFO this cycle (0..BEAT_BYTES) |
| mac_wr_eof | input | 1 | A frame finished being written this cycle |
| dma_rd_bytes | input | BEAT_W (4) | Bytes read out of the FIFO this cycle |
| dma_frame_done | input | 1 | A frame was fully drained this cycle |
| cfg_byte_steps | input | 8 | Byte limit field n; the limit is (n+1)*256 bytes |
| cfg_frame_limit | input | 5 | Frame limit field, clamped to 1..24 |
| fc_hold | output | 1 | Registered request telling the MAC to hold off writing |

## Verification
A beat that the bench drives before clock edge E updates the counts at E. The request that results from that beat is due at edge E+1, two edges after the driving negedge. Every beat the driver issues pushes its expected request into a queue, tagged with that due edge. The monitor pops and compares the entry at the negedge that follows the due edge. Configuration changes are made only after two idle cycles with no expectation pending, so each expected value uses the limits that are actually in force at its due edge.

// File: rtl/rxq_fc_pkg.sv
package rxq_fc_pkg;
  // Size of one byte-limit step, as a power of two.
  localparam int unsigned STEP_LOG2     = 8;
  // Legal range of the frame limit.
  localparam int unsigned FRM_LIMIT_MIN = 1;
  localparam int unsigned FRM_LIMIT_MAX = 24;

  typedef struct packed {
    logic bytes_over;
    logic frames_over;
  } over_t;
endpackage

// File: rtl/rxq_byte_occ.sv
module rxq_byte_occ #(
  parameter int BEAT_W = 4,
  parameter int OCC_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BEAT_W-1:0] add_bytes,
  input  logic [BEAT_W-1:0] sub_bytes,
  output logic [OCC_W-1:0]  occ
);
  localparam logic [OCC_W:0] CEIL = {1'b0, {OCC_W{1'b1}}};

  logic [OCC_W-1:0] occ_q;
  logic [OCC_W:0]   gain, sub_x, net;
  logic             floor_hit, ceil_hit;

  always_comb begin
    gain      = {1'b0, occ_q} + (OCC_W+1)'(add_bytes);
    sub_x     = (OCC_W+1)'(sub_bytes);
    floor_hit = gain < sub_x;
    net       = gain - sub_x;
    ceil_hit  = !floor_hit && (net > CEIL);
  end

  always_ff @(posedge clk) begin
    if (rst)            occ_q <= '0;
    else if (floor_hit) occ_q <= '0;
    else if (ceil_hit)  occ_q <= {OCC_W{1'b1}};
    else                occ_q <= net[OCC_W-1:0];
  end

  assign occ = occ_q;

  // R2: netted write/read update
  p_net_update_r2: assert property (@(posedge clk) disable iff (rst)
    (!floor_hit && !ceil_hit) |=> ({1'b0, occ_q} == $past(gain) - $past(sub_x)));
  // R3: over-read floors at zero
  p_floor_zero_r3: assert property (@(posedge clk) disable iff (rst)
    floor_hit |=> (occ_q == '0));
endmodule

// File: rtl/rxq_frame_occ.sv
module rxq_frame_occ #(
  parameter int FRM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_in,
  input  logic             frame_out,
  output logic [FRM_W-1:0] frames
);
  logic [FRM_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else begin
      unique case ({frame_in, frame_out})
        2'b10:   if (cnt_q != {FRM_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign frames = cnt_q;

  // R5: simultaneous end-of-frame and drain cancel
  p_both_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_in && frame_out) |=> $stable(cnt_q));
  // R5: drain at empty stays at zero
  p_drain_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && frame_out && !frame_in) |=> (cnt_q == '0));
endmodule

// File: rtl/rxq_thresh_req.sv
module rxq_thresh_req
  import rxq_fc_pkg::*;
#(
  parameter int OCC_W = 18,
  parameter int FRM_W = 6,
  parameter int BTH_W = 8,
  parameter int FTH_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCC_W-1:0] byte_occ,
  input  logic [FRM_W-1:0] frame_occ,
  input  logic [BTH_W-1:0] byte_steps,
  input  logic [FTH_W-1:0] frame_field,
  output logic [OCC_W-1:0] byte_limit,
  output logic [FTH_W-1:0] frame_limit,
  output logic             hold
);
  logic [BTH_W:0] steps_p1;
  over_t          over;
  logic           hold_q;

  always_comb begin
    steps_p1   = {1'b0, byte_steps} + 1'b1;
    byte_limit = OCC_W'(steps_p1) << STEP_LOG2;
    if (frame_field < FTH_W'(FRM_LIMIT_MIN))      frame_limit = FTH_W'(FRM_LIMIT_MIN);
    else if (frame_field > FTH_W'(FRM_LIMIT_MAX)) frame_limit = FTH_W'(FRM_LIMIT_MAX);
    else                                          frame_limit = frame_field;
    over.bytes_over  = byte_occ > byte_limit;
    over.frames_over = frame_occ > FRM_W'(frame_limit);
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= over.bytes_over | over.frames_over;
  end

  assign hold = hold_q;

  // R6: decoded frame limit always inside the legal range
  p_limit_range_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_limit >= FTH_W'(FRM_LIMIT_MIN)) && (frame_limit <= FTH_W'(FRM_LIMIT_MAX)));
endmodule

// File: rtl/rxq_hold_monitor.sv
module rxq_hold_monitor #(
  parameter int BEAT_BYTES = 8,
  parameter int OCC_W      = 18,
  parameter int FRM_W      = 6,
  parameter int BTH_W      = 8,
  parameter int FTH_W      = 5,
  localparam int BEAT_W    = $clog2(BEAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BEAT_W-1:0] mac_wr_bytes,
  input  logic              mac_wr_eof,
  input  logic [BEAT_W-1:0] dma_rd_bytes,
  input  logic              dma_frame_done,
  input  logic [BTH_W-1:0]  cfg_byte_steps,
  input  logic [FTH_W-1:0]  cfg_frame_limit,
  output logic              fc_hold
);
  logic [OCC_W-1:0] byte_occ, byte_limit;
  logic [FRM_W-1:0] frame_occ;
  logic [FTH_W-1:0] frame_limit;

  rxq_byte_occ #(.BEAT_W(BEAT_W), .OCC_W(OCC_W)) u_bytes (
    .clk(clk), .rst(rst), .add_bytes(mac_wr_bytes), .sub_bytes(dma_rd_bytes),
    .occ(byte_occ));

  rxq_frame_occ #(.FRM_W(FRM_W)) u_frames (
    .clk(clk), .rst(rst), .frame_in(mac_wr_eof), .frame_out(dma_frame_done),
    .frames(frame_occ));

  rxq_thresh_req #(.OCC_W(OCC_W), .FRM_W(FRM_W), .BTH_W(BTH_W), .FTH_W(FTH_W)) u_req (
    .clk(clk), .rst(rst), .byte_occ(byte_occ), .frame_occ(frame_occ),
    .byte_steps(cfg_byte_steps), .frame_field(cfg_frame_limit),
    .byte_limit(byte_limit), .frame_limit(frame_limit), .hold(fc_hold));

  // R4 / R7: byte condition alone raises the request one edge later
  p_bytes_raise_r4: assert property (@(posedge clk) disable iff (rst)
    (byte_occ > byte_limit) |=> fc_hold);
  // R6 / R7: frame condition alone raises the request one edge later
  p_frames_raise_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_occ > FRM_W'(frame_limit)) |=> fc_hold);
  // R8: release one edge after both counts are at or below their limits
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    ((byte_occ <= byte_limit) && (frame_occ <= FRM_W'(frame_limit))) |=> !fc_hold);
  // R1: reset clears the request
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !fc_hold);
endmodule

// File: tb/test_rxq_hold_monitor.sv
module test_rxq_hold_monitor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] mac_wr_bytes = '0;
  logic       mac_wr_eof = 1'b0;
  logic [3:0] dma_rd_bytes = '0;
  logic       dma_frame_done = 1'b0;
  logic [7:0] cfg_byte_steps = '0;
  logic [4:0] cfg_frame_limit = '0;
  logic       fc_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_hold_monitor i_rxq_hold_monitor (
    .clk(clk), .rst(rst), .mac_wr_bytes(mac_wr_bytes), .mac_wr_eof(mac_wr_eof),
    .dma_rd_bytes(dma_rd_bytes), .dma_frame_done(dma_frame_done),
    .cfg_byte_steps(cfg_byte_steps), .cfg_frame_limit(cfg_frame_limit),
    .fc_hold(fc_hold));

  typedef struct {
    int    due;
    bit    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_total = 0;
  int    n_fail = 0;
  int    m_bytes = 0;
  int    m_frames = 0;
  int    c_steps = 0;
  int    c_flim = 0;
  bit    done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit act, input bit exp, input string tag);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: fc_hold=%0b expected %0b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: compares each expectation at the negedge after its due edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      check(fc_hold, q[0].exp, q[0].tag);
      void'(q.pop_front());
    end
  end

  function automatic int clamp_f(input int f);
    if (f < 1)  return 1;
    if (f > 24) return 24;
    return f;
  endfunction

  // Driver: one beat, with its expected request queued for edge E+1
  task automatic beat(input int wr, input bit eof, input int rd, input bit fdone,
                      input string tag);
    item_t it;
    @(negedge clk);
    mac_wr_bytes   = 4'(wr);
    mac_wr_eof     = eof;
    dma_rd_bytes   = 4'(rd);
    dma_frame_done = fdone;
    m_bytes = m_bytes + wr - rd;
    if (m_bytes < 0) m_bytes = 0;
    if (eof && !fdone) m_frames++;
    else if (fdone && !eof && m_frames > 0) m_frames--;
    it.due = cyc + 2;
    it.exp = (m_bytes > (c_steps + 1) * 256) || (m_frames > clamp_f(c_flim));
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic set_cfg(input int steps, input int flim);
    repeat (2) begin
      @(negedge clk);
      mac_wr_bytes = '0; mac_wr_eof = 0; dma_rd_bytes = '0; dma_frame_done = 0;
    end
    cfg_byte_steps  = 8'(steps);
    cfg_frame_limit = 5'(flim);
    c_steps = steps;
    c_flim  = flim;
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) #1;
    if (!done_flag) begin
      done_flag = 1;
      n_total++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    // R1: traffic during reset must be discarded
    mac_wr_bytes = 4'd8; mac_wr_eof = 1; cfg_byte_steps = 0; cfg_frame_limit = 5'd31;
    c_steps = 0; c_flim = 31;
    repeat (4) @(negedge clk);
    check(fc_hold, 1'b0, "R1 hold low in reset");
    rst = 0;
    mac_wr_bytes = '0; mac_wr_eof = 0;

    // R1/R4: exactly 256 bytes with limit 256 -> no hold
    for (int i = 0; i < 32; i++) beat(8, 0, 0, 0, "R1 R4 fill to limit");
    beat(1, 0, 0, 0, "R4 R7 one byte over limit");
    beat(0, 0, 1, 0, "R8 release at limit");
    // R2: netted updates
    beat(5, 0, 5, 0, "R2 equal write and read");
    beat(8, 0, 3, 0, "R2 net gain crosses");
    beat(3, 0, 8, 0, "R2 net loss back to limit");
    // R3: over-read floors at zero
    for (int i = 0; i < 32; i++) beat(0, 0, 8, 0, "R3 drain");
    beat(0, 0, 8, 0, "R3 read when empty");
    beat(0, 0, 8, 0, "R3 read when empty again");
    for (int i = 0; i < 32; i++) beat(8, 0, 0, 0, "R3 refill after floor");
    beat(1, 0, 0, 0, "R3 R4 one over after floor");
    for (int i = 0; i < 33; i++) beat(0, 0, 8, 0, "R3 drain again");

    // R5/R6/R7: frame limit 3
    set_cfg(255, 3);
    for (int i = 0; i < 3; i++) beat(0, 1, 0, 0, "R6 frames to limit");
    beat(0, 1, 0, 0, "R6 R7 frame over limit");
    beat(0, 1, 0, 1, "R5 eof and drain together");
    beat(0, 0, 0, 1, "R5 R8 drain releases");
    for (int i = 0; i < 3; i++) beat(0, 0, 0, 1, "R5 drain to zero");
    beat(0, 0, 0, 1, "R5 drain at empty");

    // R6: field 0 reads as 1
    set_cfg(255, 0);
    beat(0, 1, 0, 0, "R5 R6 one frame at clamped limit");
    beat(0, 1, 0, 0, "R6 two frames over clamped 1");
    beat(0, 0, 0, 1, "R6 drain");
    beat(0, 0, 0, 1, "R6 drain");

    // R6: field 31 reads as 24
    set_cfg(255, 31);
    for (int i = 0; i < 24; i++) beat(0, 1, 0, 0, "R6 frames to clamped 24");
    beat(0, 1, 0, 0, "R6 frame 25 over");
    for (int i = 0; i < 25; i++) beat(0, 0, 0, 1, "R6 drain frames");

    // R4: largest byte limit 65536
    for (int i = 0; i < 8192; i++) beat(8, 0, 0, 0, "R4 fill to 65536");
    beat(1, 0, 0, 0, "R4 R7 over largest limit");
    beat(0, 0, 1, 0, "R8 release at largest limit");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_total++; n_fail++;
      $display("FAIL R8: pending expectations=%0d expected 0", q.size());
    end
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule